// File: doc/BRIEF.md
# Burst Column Offset Sequencer

This block turns one burst request into the ordered series of column addresses that a DDR2-style memory walks through during a read or write burst. A request carries a start strobe, a full column address, a length select (four or eight beats) and an ordering select (sequential or interleaved). Once a request is taken, the block emits one column address per clock, with a valid flag, the beat number and a flag on the final beat.

Only the three lowest column bits are reordered. The bits above them are captured with the request and presented unchanged on every beat. The length and ordering selects are also captured, so the memory controller may change its inputs freely while a burst runs. A new request is taken only when no burst is running. Requests that arrive while a burst is running are dropped, not queued.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst_n` is low, and for the clocks the internal reset release takes afterwards, `vld_o` and `last_o` are 0 and a start request is not taken.
- R2: A `start_i` high at a rising edge while `vld_o` is 0 is taken. From the next cycle `vld_o` is 1 for consecutive cycles, `beat_o` counts 0,1,2,... and beat 0 shows the requested column address unchanged.
- R3: With `bl8_i`=0 (four beats) and `intlv_i`=0 (sequential), the offset in `col_o[1:0]` is the start value plus the beat number, modulo 4 (start 1 gives 1,2,3,0).
- R4: With `bl8_i`=0 and `intlv_i`=1 (interleaved), `col_o[1:0]` is the start value XOR the beat number (start 3 gives 3,2,1,0).
- R5: With `bl8_i`=1 (eight beats) and `intlv_i`=0, `col_o[1:0]` wraps modulo 4 from the start value within each group of four beats, and `col_o[2]` is the start bit 2 for beats 0-3 and its inverse for beats 4-7 (start 5 gives 5,6,7,4,1,2,3,0).
- R6: With `bl8_i`=1 and `intlv_i`=1, `col_o[2:0]` is the 3-bit start value XOR the beat number (start 5 gives 5,4,7,6,1,0,3,2).
- R7: The column bits above bit 2 equal the requested ones on every beat. In four-beat bursts `col_o[2]` also keeps its requested value on every beat.
- R8: `last_o` is 1 only on beat 3 of a four-beat burst and beat 7 of an eight-beat burst. `vld_o` is 0 on the cycle after the last beat.
- R9: A start request at an edge where `vld_o` is 1, including the last-beat edge, is ignored. Changes of `col_i`, `bl8_i` and `intlv_i` during a burst do not affect its addresses, length or ordering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst request strobe |
| col_i | input | COL_W | Requested starting column address |
| bl8_i | input | 1 | Length select: 0 = four beats, 1 = eight beats |
| intlv_i | input | 1 | Ordering select: 0 = sequential, 1 = interleaved |
| vld_o | output | 1 | A burst beat is presented |
| last_o | output | 1 | Presented beat is the final one |
| beat_o | output | 3 | Beat number within the burst |
| col_o | output | COL_W | Column address for the presented beat |

## Verification
The embedded properties check on every cycle that beats step by one and end one cycle after the last flag, and that captured settings and upper bits stay still while a burst runs. They also check the local ordering laws: a +1 step of the low bits within a sequential nibble, a constant XOR distance in interleaved mode, bit 2 held in four-beat bursts and flipped at the nibble boundary in eight-beat bursts. Properties cannot show that the full sequence matches the start value, or that the requested column appears on beat 0. The bench covers both by comparing every beat of all 32 start, length and type combinations, and of random bursts with noisy inputs mid-burst, against its own reference. It also checks the four published example orders literally.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BURST_MAX = 8;
  localparam int unsigned OFS_W     = $clog2(BURST_MAX);

  typedef enum logic {BL_FOUR = 1'b0, BL_EIGHT = 1'b1} blen_e;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_XOR  = 1'b1} btype_e;

  typedef struct packed {
    blen_e              blen;
    btype_e             btype;
    logic [OFS_W-1:0]   ofs;
  } burst_cfg_t;
endpackage

// File: rtl/burst_seq_rst_sync.sv
module burst_seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int unsigned UP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  burst_cfg_t       cfg_i,
  input  logic [UP_W-1:0]  upper_i,
  output logic             active_o,
  output logic             last_o,
  output logic [OFS_W-1:0] beat_o,
  output burst_cfg_t       cfg_o,
  output logic [UP_W-1:0]  upper_o
);
  localparam logic [OFS_W-1:0] LAST4 = OFS_W'(BURST_MAX/2 - 1);
  localparam logic [OFS_W-1:0] LAST8 = OFS_W'(BURST_MAX - 1);

  logic             active_q, active_d;
  logic [OFS_W-1:0] beat_q, beat_d;
  burst_cfg_t       cfg_q;
  logic [UP_W-1:0]  upper_q;
  logic             accept, cap_en, at_last;
  logic [OFS_W-1:0] last_idx;

  always_comb begin
    last_idx = (cfg_q.blen == BL_EIGHT) ? LAST8 : LAST4;
    at_last  = active_q && (beat_q == last_idx);
    accept   = start_i && !active_q;
    cap_en   = 1'b0;
    active_d = active_q;
    beat_d   = beat_q;
    if (accept) begin
      cap_en   = 1'b1;
      active_d = 1'b1;
      beat_d   = '0;
    end else if (at_last) begin
      active_d = 1'b0;
      beat_d   = '0;
    end else if (active_q) begin
      beat_d   = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      cfg_q   <= cfg_i;
      upper_q <= upper_i;
    end
  end

  assign active_o = active_q;
  assign last_o   = at_last;
  assign beat_o   = beat_q;
  assign cfg_o    = cfg_q;
  assign upper_o  = upper_q;

  // R8
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !active_o);

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !active_o) |=> (active_o && beat_o == '0));

  // R9
  hold_mid_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !last_o) |=> (active_o && beat_o == OFS_W'($past(beat_o) + 1'b1)
                               && $stable(cfg_o) && $stable(upper_o)));

  // R8
  short_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && cfg_o.blen == BL_FOUR) |-> !beat_o[OFS_W-1]);
endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order
  import burst_seq_pkg::*;
(
  input  burst_cfg_t       cfg_i,
  input  logic [OFS_W-1:0] beat_i,
  output logic [OFS_W-1:0] ofs_o
);
  localparam int unsigned LO_W = OFS_W - 1;

  logic [LO_W-1:0] lo_seq, lo_xor;
  logic            nib_flip;

  always_comb begin
    lo_seq   = cfg_i.ofs[LO_W-1:0] + beat_i[LO_W-1:0];
    nib_flip = (cfg_i.blen == BL_EIGHT) & beat_i[OFS_W-1];
  end

  for (genvar i = 0; i < LO_W; i++) begin : g_xor
    assign lo_xor[i] = cfg_i.ofs[i] ^ beat_i[i];
  end

  always_comb begin
    ofs_o[OFS_W-1]  = cfg_i.ofs[OFS_W-1] ^ nib_flip;
    ofs_o[LO_W-1:0] = (cfg_i.btype == ORD_XOR) ? lo_xor : lo_seq;
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             bl8_i,
  input  logic             intlv_i,
  output logic             vld_o,
  output logic             last_o,
  output logic [2:0]       beat_o,
  output logic [COL_W-1:0] col_o
);
  localparam int unsigned UP_W = COL_W - OFS_W;

  logic             rst_q_n;
  burst_cfg_t       req_cfg, cur_cfg;
  logic [UP_W-1:0]  upper_q;
  logic [OFS_W-1:0] beat;
  logic [OFS_W-1:0] ofs;
  logic             active, last_beat;

  assign req_cfg = '{blen: blen_e'(bl8_i), btype: btype_e'(intlv_i), ofs: col_i[OFS_W-1:0]};

  burst_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  burst_seq_ctrl #(.UP_W(UP_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .start_i  (start_i),
    .cfg_i    (req_cfg),
    .upper_i  (col_i[COL_W-1:OFS_W]),
    .active_o (active),
    .last_o   (last_beat),
    .beat_o   (beat),
    .cfg_o    (cur_cfg),
    .upper_o  (upper_q)
  );

  burst_seq_order u_order (
    .cfg_i  (cur_cfg),
    .beat_i (beat),
    .ofs_o  (ofs)
  );

  assign vld_o  = active;
  assign last_o = last_beat;
  assign beat_o = beat;
  assign col_o  = {upper_q, ofs};

  // R8
  last_has_vld_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    last_o |-> vld_o);

  // R7
  a2_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vld_o && !last_o && cur_cfg.blen == BL_FOUR) |=> (col_o[2] == $past(col_o[2])));

  // R5
  nibble_flip_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vld_o && beat_o == 3'd3 && cur_cfg.blen == BL_EIGHT) |=> (col_o[2] != $past(col_o[2])));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vld_o && !last_o && cur_cfg.btype == ORD_SEQ && beat_o[1:0] != 2'd3)
      |=> (col_o[1:0] == 2'($past(col_o[1:0]) + 2'd1)));

  // R4
  xor_dist_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vld_o && !last_o && cur_cfg.btype == ORD_XOR)
      |=> ((col_o[1:0] ^ beat_o[1:0]) == ($past(col_o[1:0]) ^ $past(beat_o[1:0]))));

  // R7
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (vld_o && !last_o) |=> $stable(col_o[COL_W-1:OFS_W]));
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] col_i;
  logic             bl8_i, intlv_i;
  logic             vld_o, last_o;
  logic [2:0]       beat_o;
  logic [COL_W-1:0] col_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int got [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
    .bl8_i(bl8_i), .intlv_i(intlv_i), .vld_o(vld_o), .last_o(last_o),
    .beat_o(beat_o), .col_o(col_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_ofs(int s, int b, bit bl8, bit intlv);
    int lo, hi;
    if (intlv) return bl8 ? (s ^ b) : ((s & 4) | ((s ^ b) & 3));
    lo = ((s % 4) + (b % 4)) % 4;
    hi = s / 4;
    if (bl8 && b >= 4) hi = 1 - hi;
    return hi * 4 + lo;
  endfunction

  function automatic string mode_req(bit bl8, bit intlv);
    if (!bl8) return intlv ? "R4" : "R3";
    return intlv ? "R6" : "R5";
  endfunction

  // Called at a falling edge with vld_o low; returns at the falling edge after the burst.
  task automatic run_burst(logic [COL_W-1:0] col, bit bl8, bit intlv, bit noise);
    int n = bl8 ? 8 : 4;
    start_i = 1'b1; col_i = col; bl8_i = bl8; intlv_i = intlv;
    @(posedge clk); @(negedge clk);
    for (int b = 0; b < n; b++) begin
      if (noise) begin
        start_i = 1'($urandom % 2); col_i = COL_W'($urandom);
        bl8_i = 1'($urandom % 2); intlv_i = 1'($urandom % 2);
      end else begin
        start_i = 1'b0;
      end
      chk("R2", "valid", int'(vld_o), 1);
      chk("R2", "beat", int'(beat_o), b);
      chk(noise ? "R9" : mode_req(bl8, intlv), "offset", int'(col_o[2:0]),
          exp_ofs(int'(col[2:0]), b, bl8, intlv));
      chk("R7", "upper", int'(col_o[COL_W-1:3]), int'(col[COL_W-1:3]));
      if (!bl8) chk("R7", "bit2", int'(col_o[2]), int'(col[2]));
      chk("R8", "last", int'(last_o), (b == n-1) ? 1 : 0);
      got[b] = int'(col_o[2:0]);
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(noise ? "R9" : "R8", "valid after last", int'(vld_o), 0);
    chk("R8", "last after burst", int'(last_o), 0);
  endtask

  task automatic cmp_list(string req, int n, int e0, int e1, int e2, int e3,
                          int e4, int e5, int e6, int e7);
    int e [8];
    e = '{e0, e1, e2, e3, e4, e5, e6, e7};
    for (int i = 0; i < n; i++) chk(req, "example order", got[i], e[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start_i = 1'b1; col_i = '0; bl8_i = 1'b0; intlv_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", int'(vld_o), 0);
    chk("R1", "last in reset", int'(last_o), 0);
    rst_n = 1'b1; start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "valid after release", int'(vld_o), 0);

    // published example orders
    run_burst(10'h3A5, 1'b1, 1'b0, 1'b0); cmp_list("R5", 8, 5, 6, 7, 4, 1, 2, 3, 0);
    run_burst(10'h105, 1'b1, 1'b1, 1'b0); cmp_list("R6", 8, 5, 4, 7, 6, 1, 0, 3, 2);
    run_burst(10'h0F9, 1'b0, 1'b0, 1'b0); cmp_list("R3", 4, 1, 2, 3, 0, 0, 0, 0, 0);
    run_burst(10'h20B, 1'b0, 1'b1, 1'b0); cmp_list("R4", 4, 3, 2, 1, 0, 0, 0, 0, 0);

    // every start offset, length and ordering
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 4; m++)
        run_burst(COL_W'({$urandom % 128, 3'(s)}), m[1], m[0], 1'b0);

    // random bursts with noisy inputs and idle gaps
    for (int k = 0; k < 300; k++) begin
      run_burst(COL_W'($urandom), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
      repeat ($urandom % 3) begin
        @(negedge clk);
        chk("R8", "idle valid", int'(vld_o), 0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule